// File: doc/BRIEF.md
# Alarm Compare and Event Status Unit

This block sits beside a BCD calendar counter. It holds a six-field BCD alarm time: second, minute, hour, day, month and year. Each time the counter signals a fresh time value, the block compares that value with the stored alarm. Every field must be equal for a match, including the year, because there are no wildcard fields. A match sets a sticky alarm flag.

The same status register records four rollover events (second, minute, hour, day) and a power-up flag that reset sets. Software clears a status bit by writing one to it. An enable register gates two interrupt lines:
- a level alarm interrupt, which follows the sticky flag;
- a one-cycle timer pulse on each time update.

Register access is a simple byte port. A write takes effect at the clock edge where it is presented. Reads are combinational from the current register contents.

Top module: `alarm_evt_unit`

## Requirements
- R1: After a synchronous active-low reset, all six alarm fields read 0x00 and the enable register reads 0x00. The status register reads 0x80: the power-up flag is set and every other bit is clear. Both interrupt outputs are low.
- R2: The alarm field k (k = 0..5 for second, minute, hour, day, month, year) is an 8-bit register at offset 0x20 + 4k. A write stores the byte, and a read of that offset returns it. A read of any unmapped offset returns 0x00.
- R3: When `upd_tick_i` is high and all six bytes of `time_i` equal the alarm fields, status bit 6 reads 1 from the next cycle on. In `time_i`, field k sits at bits [8k+7:8k]. Status bit 6 is never set in a cycle without a tick.
- R4: A tick where any single field differs, the year included, leaves status bit 6 unchanged.
- R5: Status bit 6 is sticky. Writing 1 to bit 6 at offset 0x44 clears it, and writing 0 to that bit leaves it unchanged. If a clear and a matching tick arrive in the same cycle, the bit is set.
- R6: Status bit 7 (power-up) is set only by reset and is cleared by writing 1 to bit 7 at offset 0x44.
- R7: On each tick, status bits 2, 3, 4 and 5 are loaded from `roll_i[0]` through `roll_i[3]` (second, minute, hour, day). Between ticks, writing 1 to one of these bits clears it. A tick overrides a clear written in the same cycle. Status bits 1:0 always read 0.
- R8: The enable register at offset 0x48 keeps bit 3 (alarm enable) and bit 2 (timer enable). Its other bits read 0.
- R9: `irq_alarm_o` is high exactly while status bit 6 and enable bit 3 are both 1. It is a level output.
- R10: `irq_timer_o` is high for exactly the one cycle that follows a tick, provided enable bit 2 was 1 in the tick cycle. Otherwise it is low.
- R11: After 0x00 is written to offset 0x48, `irq_alarm_o` is low from the next cycle on. No later tick raises `irq_timer_o` until an enable is written again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_tick_i | input | 1 | One-cycle pulse marking a new valid time value |
| time_i | input | 48 | Current BCD time; field k at bits [8k+7:8k] |
| roll_i | input | 4 | Rollover events for this update: second, minute, hour, day |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register byte offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Combinational read data for `reg_addr_i` |
| irq_timer_o | output | 1 | Periodic timer interrupt pulse |
| irq_alarm_o | output | 1 | Level alarm interrupt |

## Verification
Inputs change on the falling edge. Register writes, the alarm flag, the event bits and the timer pulse all change at the next rising edge, one cycle after the stimulus, so the bench samples them 1 ns after that edge. `irq_alarm_o` is a combinational AND of two registers, so it is due in the same cycle as the flag or enable change that drives it. Read data is combinational and is sampled 1 ns after the address is driven, before the edge that applies any write in that step. Expected values come from a bench model that is updated with the same edge ordering:
- the compare uses the alarm value held before a same-cycle write;
- a tick wins over a write-one-to-clear.

// File: rtl/alarm_evt_pkg.sv
// Package: shared geometry and register map of the alarm/event unit.
// Assumes byte-wide registers on a word-spaced offset map.
package alarm_evt_pkg;
    localparam int ADDR_W      = 7;
    localparam int DATA_W      = 8;
    localparam int NUM_FIELDS  = 6;
    localparam int FIELD_W     = 8;
    localparam int NUM_EVT     = 4;
    localparam int ALM_BASE    = 'h20;
    localparam int ALM_STRIDE  = 4;
    localparam int STAT_OFS    = 'h44;
    localparam int IEN_OFS     = 'h48;
    localparam int ST_PWRUP    = 7;
    localparam int ST_ALARM    = 6;
    localparam int ST_EVT_LO   = 2;
    localparam int IEN_ALARM   = 3;
    localparam int IEN_TIMER   = 2;
    localparam int TIME_W      = NUM_FIELDS * FIELD_W;
endpackage

// File: rtl/alarm_field_regs.sv
// Module: alarm_field_regs
// Holds the BCD alarm fields, one byte register per field at
// BASE + k*STRIDE. It also returns read data and a hit flag for those
// offsets. Assumes single-cycle writes with no byte enables.
module alarm_field_regs #(
    parameter int NF     = 6,
    parameter int FW     = 8,
    parameter int AW     = 7,
    parameter int BASE   = 'h20,
    parameter int STRIDE = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [FW-1:0]    wdata_i,
    output logic [NF*FW-1:0] alm_o,
    output logic             hit_o,
    output logic [FW-1:0]    rdata_o
);
    logic [NF-1:0]    sel;
    logic [FW-1:0]    rd_terms [NF];

    for (genvar g = 0; g < NF; g++) begin : g_fld
        localparam logic [AW-1:0] FOFS = AW'(BASE + g * STRIDE);
        logic [FW-1:0] fld_q;

        assign sel[g] = (addr_i == FOFS);

        // Field storage: load on a write to this field's offset.
        always_ff @(posedge clk) begin
            if (!rst_n)              fld_q <= '0;
            else if (we_i && sel[g]) fld_q <= wdata_i;
        end

        assign alm_o[g*FW +: FW] = fld_q;
        assign rd_terms[g]       = sel[g] ? fld_q : '0;

        a_r2_field_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
            (we_i && sel[g]) |=> (alm_o[g*FW +: FW] == $past(wdata_i)));
    end

    // Read return: OR of the per-field terms; at most one is selected.
    always_comb begin
        rdata_o = '0;
        for (int k = 0; k < NF; k++) rdata_o = rdata_o | rd_terms[k];
    end

    assign hit_o = |sel;
endmodule

// File: rtl/alarm_match.sv
// Module: alarm_match
// Compares every alarm field with the live time and gives a full match.
// No field is a wildcard. Assumes both vectors use the same field order.
module alarm_match #(
    parameter int NF = 6,
    parameter int FW = 8
) (
    input  logic [NF*FW-1:0] time_i,
    input  logic [NF*FW-1:0] alm_i,
    output logic             match_o
);
    logic [NF-1:0] eq;

    for (genvar g = 0; g < NF; g++) begin : g_cmp
        assign eq[g] = (time_i[g*FW +: FW] == alm_i[g*FW +: FW]);
    end

    // Full match: every field must agree.
    assign match_o = &eq;
endmodule

// File: rtl/status_flags.sv
// Module: status_flags
// Status register with a sticky alarm flag, a power-up flag set by reset,
// and rollover event bits reloaded on each time update. Writing one
// clears a bit. A same-cycle update wins over a clear.
module status_flags #(
    parameter int DW     = 8,
    parameter int NE     = 4,
    parameter int EVT_LO = 2,
    parameter int B_ALM  = 6,
    parameter int B_PWR  = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          match_i,
    input  logic [NE-1:0] roll_i,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] stat_o
);
    logic          pwr_q;
    logic          alm_q;
    logic [NE-1:0] evt_q;

    // Power-up flag: set by reset, cleared only by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)                      pwr_q <= 1'b1;
        else if (we_i && wdata_i[B_PWR]) pwr_q <= 1'b0;
    end

    // Alarm flag: set by a match on an update, else cleared by write-one.
    always_ff @(posedge clk) begin
        if (!rst_n)                      alm_q <= 1'b0;
        else if (tick_i && match_i)      alm_q <= 1'b1;
        else if (we_i && wdata_i[B_ALM]) alm_q <= 1'b0;
    end

    // Event bits: reload on each update, else clear the bits written one.
    always_ff @(posedge clk) begin
        if (!rst_n)      evt_q <= '0;
        else if (tick_i) evt_q <= roll_i;
        else if (we_i)   evt_q <= evt_q & ~wdata_i[EVT_LO +: NE];
    end

    // Status assembly: unused bits read zero.
    always_comb begin
        stat_o               = '0;
        stat_o[B_PWR]        = pwr_q;
        stat_o[B_ALM]        = alm_q;
        stat_o[EVT_LO +: NE] = evt_q;
    end

    a_r3_alarm_rise_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alm_q) |-> $past(tick_i && match_i));
    a_r5_clear_without_update: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wdata_i[B_ALM] && !tick_i) |=> !stat_o[B_ALM]);
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[B_ALM] && !(we_i && wdata_i[B_ALM])) |=> stat_o[B_ALM]);
    a_r6_pwrup_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(stat_o[B_PWR]));
    a_r7_events_follow_roll: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (stat_o[EVT_LO +: NE] == $past(roll_i)));
endmodule

// File: rtl/irq_ctrl.sv
// Module: irq_ctrl
// Interrupt-enable register and the two interrupt outputs: a one-cycle
// timer pulse after each update, and a level alarm line while the sticky
// flag and its enable are both set. Assumes one update per tick pulse.
module irq_ctrl #(
    parameter int DW    = 8,
    parameter int B_ALM = 3,
    parameter int B_TMR = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          alarm_flag_i,
    input  logic          we_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] ien_o,
    output logic          irq_timer_o,
    output logic          irq_alarm_o
);
    logic en_alm_q;
    logic en_tmr_q;
    logic tmr_q;

    // Enable register: keeps only the two defined bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_alm_q <= 1'b0;
            en_tmr_q <= 1'b0;
        end else if (we_i) begin
            en_alm_q <= wdata_i[B_ALM];
            en_tmr_q <= wdata_i[B_TMR];
        end
    end

    // Timer pulse: one cycle after an update while the timer is enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= 1'b0;
        else        tmr_q <= tick_i && en_tmr_q;
    end

    // Read view and output gating.
    always_comb begin
        ien_o        = '0;
        ien_o[B_ALM] = en_alm_q;
        ien_o[B_TMR] = en_tmr_q;
    end

    assign irq_timer_o = tmr_q;
    assign irq_alarm_o = alarm_flag_i && en_alm_q;

    a_r10_timer_after_update: assert property (@(posedge clk) disable iff (!rst_n)
        irq_timer_o |-> $past(tick_i));
    a_r9_alarm_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_o[B_ALM] |-> !irq_alarm_o);
    a_r11_zero_write_silences: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wdata_i == '0) |=> (!irq_alarm_o && ien_o == '0));
    a_r10_no_pulse_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ien_o[B_TMR] |=> !irq_timer_o);
endmodule

// File: rtl/alarm_evt_unit.sv
// Module: alarm_evt_unit (top)
// Alarm compare and event status unit. It decodes the byte register port,
// compares the alarm with each time update, and drives the timer and
// alarm interrupts. Assumes time_i is stable and valid when upd_tick_i is high.
module alarm_evt_unit
    import alarm_evt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_tick_i,
    input  logic [TIME_W-1:0] time_i,
    input  logic [NUM_EVT-1:0] roll_i,
    input  logic              reg_we_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              irq_timer_o,
    output logic              irq_alarm_o
);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_OFS);
    localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(IEN_OFS);

    logic [TIME_W-1:0] alm_vec;
    logic              alm_hit;
    logic [DATA_W-1:0] alm_rd;
    logic              match;
    logic [DATA_W-1:0] stat;
    logic [DATA_W-1:0] ien;
    logic              we_stat;
    logic              we_ien;

    // Write decode for the two control registers.
    assign we_stat = reg_we_i && (reg_addr_i == A_STAT);
    assign we_ien  = reg_we_i && (reg_addr_i == A_IEN);

    alarm_field_regs #(
        .NF(NUM_FIELDS), .FW(FIELD_W), .AW(ADDR_W),
        .BASE(ALM_BASE), .STRIDE(ALM_STRIDE)
    ) u_fields (
        .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
        .wdata_i(reg_wdata_i), .alm_o(alm_vec), .hit_o(alm_hit), .rdata_o(alm_rd)
    );

    alarm_match #(.NF(NUM_FIELDS), .FW(FIELD_W)) u_match (
        .time_i(time_i), .alm_i(alm_vec), .match_o(match)
    );

    status_flags #(
        .DW(DATA_W), .NE(NUM_EVT), .EVT_LO(ST_EVT_LO),
        .B_ALM(ST_ALARM), .B_PWR(ST_PWRUP)
    ) u_status (
        .clk(clk), .rst_n(rst_n), .tick_i(upd_tick_i), .match_i(match),
        .roll_i(roll_i), .we_i(we_stat), .wdata_i(reg_wdata_i), .stat_o(stat)
    );

    irq_ctrl #(.DW(DATA_W), .B_ALM(IEN_ALARM), .B_TMR(IEN_TIMER)) u_irq (
        .clk(clk), .rst_n(rst_n), .tick_i(upd_tick_i), .alarm_flag_i(stat[ST_ALARM]),
        .we_i(we_ien), .wdata_i(reg_wdata_i), .ien_o(ien),
        .irq_timer_o(irq_timer_o), .irq_alarm_o(irq_alarm_o)
    );

    // Read return mux; unmapped offsets read zero.
    always_comb begin
        if (alm_hit)                  reg_rdata_o = alm_rd;
        else if (reg_addr_i == A_STAT) reg_rdata_o = stat;
        else if (reg_addr_i == A_IEN)  reg_rdata_o = ien;
        else                          reg_rdata_o = '0;
    end

    a_r3_no_flag_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_tick_i && !stat[ST_ALARM]) |=> !stat[ST_ALARM]);
    a_r7_low_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        stat[1:0] == 2'b00);
endmodule

// File: tb/alarm_evt_unit_tb_top.sv
`timescale 1ns/1ps
module alarm_evt_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [47:0] tm = '0;
    logic [3:0]  rl = '0;
    logic        we = 1'b0;
    logic [6:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq_t, irq_a;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of the register state.
    logic [47:0] m_alm;
    logic [7:0]  m_st;
    logic [7:0]  m_en;
    logic        m_tp;

    always #2 clk = ~clk;

    alarm_evt_unit dut_i (
        .clk(clk), .rst_n(rst_n), .upd_tick_i(tick), .time_i(tm), .roll_i(rl),
        .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .irq_timer_o(irq_t), .irq_alarm_o(irq_a)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(input logic [6:0] a);
        if (a >= 7'h20 && a <= 7'h34 && a[1:0] == 2'b00) return m_alm[(a - 7'h20) * 2 +: 8];
        if (a == 7'h44) return m_st;
        if (a == 7'h48) return m_en;
        return 8'h00;
    endfunction

    function automatic logic [7:0] bcd(input int v);
        return 8'((v / 10) * 16 + (v % 10));
    endfunction

    function automatic logic [47:0] rand_time();
        return {bcd($urandom % 100), bcd(1 + $urandom % 12), bcd(1 + $urandom % 31),
                bcd($urandom % 24), bcd($urandom % 60), bcd($urandom % 60)};
    endfunction

    // One cycle: drive at the falling edge, check read data, apply the edge, check the interrupts.
    task automatic step(input logic w, input logic [6:0] a, input logic [7:0] d,
                        input logic tk, input logic [47:0] t, input logic [3:0] r,
                        input bit rd, input string tag);
        logic match;
        @(negedge clk);
        we = w; addr = a; wdata = d; tick = tk; tm = t; rl = r;
        #1;
        if (rd) chk(rdata == exp_read(a), tag, rdata, exp_read(a));
        @(posedge clk);
        match = tk && (t == m_alm);
        m_tp  = tk && m_en[2];
        if (w) begin
            if (a >= 7'h20 && a <= 7'h34 && a[1:0] == 2'b00) m_alm[(a - 7'h20) * 2 +: 8] = d;
            if (a == 7'h48) m_en = d & 8'h0C;
            if (a == 7'h44) m_st = m_st & ~(d & 8'hFC);
        end
        if (tk) begin
            m_st[5:2] = r;
            if (match) m_st[6] = 1'b1;
        end
        #1;
        chk(irq_a == (m_st[6] & m_en[3]), {tag, " R9 alarm irq"}, irq_a, m_st[6] & m_en[3]);
        chk(irq_t == m_tp, {tag, " R10 timer irq"}, irq_t, m_tp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [47:0] alm_set;
        void'($urandom(32'd4242));
        m_alm = '0; m_st = 8'h80; m_en = '0; m_tp = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        // R1: reset state at every mapped offset, outputs low
        chk(irq_a == 1'b0 && irq_t == 1'b0, "R1 irq outputs after reset", {irq_a, irq_t}, 0);
        for (int k = 0; k < 6; k++) step(0, 7'(7'h20 + 4 * k), 0, 0, '1, 0, 1, "R1 alarm field reset");
        step(0, 7'h44, 0, 0, '1, 0, 1, "R1 status reset");
        step(0, 7'h48, 0, 0, '1, 0, 1, "R1 enable reset");

        // R2: directed alarm field writes and readback, unmapped offset
        alm_set = {8'h99, 8'h12, 8'h31, 8'h23, 8'h59, 8'h59};
        for (int k = 0; k < 6; k++) step(1, 7'(7'h20 + 4 * k), alm_set[k*8 +: 8], 0, '0, 0, 0, "R2 write");
        for (int k = 0; k < 6; k++) step(0, 7'(7'h20 + 4 * k), 0, 0, '0, 0, 1, "R2 readback");
        step(0, 7'h38, 0, 0, '0, 0, 1, "R2 unmapped read");
        step(0, 7'h21, 0, 0, '0, 0, 1, "R2 misaligned read");

        // R8: enable register keeps bits 3 and 2 only
        step(1, 7'h48, 8'hFF, 0, '0, 0, 0, "R8 write all ones");
        step(0, 7'h48, 0, 0, '0, 0, 1, "R8 readback");

        // R4: a mismatch in the year alone sets nothing
        step(0, 7'h44, 0, 1, {8'h98, alm_set[39:0]}, 4'b0001, 0, "R4 year mismatch");
        step(0, 7'h44, 0, 0, '0, 0, 1, "R4 status after mismatch");
        // R3: a full match sets the flag; the timer pulses (R10)
        step(0, 7'h44, 0, 1, alm_set, 4'b1111, 0, "R3 full match");
        step(0, 7'h44, 0, 0, '0, 0, 1, "R3 status after match");
        // R5: writing zero keeps the flag; writing one clears it
        step(1, 7'h44, 8'h00, 0, '0, 0, 0, "R5 write zero");
        step(1, 7'h44, 8'h40, 0, '0, 0, 1, "R5 clear alarm");
        step(0, 7'h44, 0, 0, '0, 0, 1, "R5 status after clear");
        // R5: a clear and a match in the same cycle leave the flag set
        step(1, 7'h44, 8'h40, 1, alm_set, 4'b0001, 0, "R5 set wins");
        step(0, 7'h44, 0, 0, '0, 0, 1, "R5 status after race");
        // R6: clear the power-up flag
        step(1, 7'h44, 8'h80, 0, '0, 0, 0, "R6 clear pwrup");
        step(0, 7'h44, 0, 1, '0, 4'b0101, 1, "R6 status after clear");
        // R7: event bits load on a tick, then clear by write-one
        step(1, 7'h44, 8'h04, 0, '0, 0, 1, "R7 events loaded");
        step(0, 7'h44, 0, 0, '0, 0, 1, "R7 event partly cleared");
        step(1, 7'h44, 8'h3C, 1, '0, 4'b1010, 0, "R7 tick beats clear");
        step(0, 7'h44, 0, 0, '0, 0, 1, "R7 status after tick and clear");
        // R11: writing zero to enable silences both lines
        step(1, 7'h48, 8'h00, 0, '0, 0, 0, "R11 disable");
        step(0, 7'h48, 0, 1, alm_set, 4'b0001, 1, "R11 tick while disabled");
        step(0, 7'h44, 0, 0, '0, 0, 1, "R11 status still tracks");

        // Random traffic mixed with near and full matches
        for (int i = 0; i < 4000; i++) begin
            int kind;
            int sel;
            logic [47:0] t;
            logic [6:0]  a;
            logic [7:0]  d;
            kind = $urandom % 8;
            t = rand_time();
            if (kind < 2) t = m_alm;
            else if (kind < 4) begin
                t = m_alm;
                sel = $urandom % 6;
                t[sel*8 +: 8] = t[sel*8 +: 8] ^ 8'(1 + $urandom % 255);
            end
            sel = $urandom % 9;
            if (sel < 6) a = 7'(7'h20 + 4 * sel);
            else if (sel == 6) a = 7'h44;
            else if (sel == 7) a = 7'h48;
            else a = 7'($urandom);
            d = (sel < 6) ? m_alm[sel*8 +: 8] ^ 8'($urandom % 2) : 8'($urandom);
            step(($urandom % 4) == 0, a, d, ($urandom % 3) != 0, t, 4'($urandom),
                 1, "R3 R4 R7 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule